// File: doc/BRIEF.md
# Pipelined single-precision floating-point multiplier

This block multiplies two 32-bit binary floating-point numbers (1 sign bit, 8-bit biased exponent with bias 127, 23 stored fraction bits with an implied leading one) through three register stages. It takes a new operand pair on every clock and returns each product, with a matching valid strobe, exactly three cycles later.

No rounding is done. Beside the packed 32-bit result, whose fraction is simply truncated, the block presents the full 48-bit normalised significand product so that a following accumulator can keep every bit. Exponent overflow and underflow are flagged and saturate to a signed infinity or a signed zero. Subnormal inputs are flushed to zero. NaN and infinity operands follow the usual special-value rules.

Top module: `fp32_mul_pipe`

## Requirements
- R1: Operands and result use the 32-bit layout: bit 31 sign, bits 30:23 exponent biased by 127, bits 22:0 fraction with an implied leading one. An exponent field of 255 with a zero fraction is infinity. An exponent field of 255 with a nonzero fraction is NaN.
- R2: `res_valid` equals `op_valid` delayed by exactly three clock cycles. A new operand pair is accepted every cycle, and back-to-back pairs give back-to-back results in order.
- R3: The result sign is the XOR of the operand signs. This includes zero, infinity, overflow and underflow results, but not NaN.
- R4: For finite in-range operands, the result exponent is ea + eb - 127, plus the normalisation increment. The result fraction is bits 45:23 of the normalised product, truncated with no rounding.
- R5: When bit 47 of the 24x24-bit significand product is set, the product shifts right by one and the exponent increases by one. `sig_prod` carries the normalised product, which has bit 47 clear and bit 46 set, whenever the result is a finite nonzero number. In all other cases `sig_prod` is zero.
- R6: When the final biased exponent is above 254, `ovf` is 1 and the result is a correctly signed infinity.
- R7: When the final biased exponent is below 1, `udf` is 1 and the result is a correctly signed zero.
- R8: An operand whose exponent field is 0 counts as zero, whatever its fraction. A zero operand times a finite operand gives a signed zero with both flags clear.
- R9: Any NaN operand, or infinity times zero, gives 0x7FC00000 with both flags clear.
- R10: Infinity times a nonzero non-NaN operand gives a signed infinity with `ovf` clear.
- R11: An active-high synchronous `rst` clears every valid stage. `res_valid` is low in the cycle after reset, and an operand pair in flight during reset never produces a result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operand pair valid |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| res_valid | output | 1 | Result valid, three cycles after op_valid |
| res | output | 32 | Packed result, truncated fraction |
| sig_prod | output | 48 | Normalised unrounded significand product |
| ovf | output | 1 | Exponent overflow |
| udf | output | 1 | Exponent underflow |

## Verification
The exponent boundaries are the hardest cases to reach: the final exponent has to land exactly on 254 or 1, or one step beyond either, and the normalisation increment decides which side it falls on. The stimulus uses operand pairs whose exponents sum to each edge, with significands chosen so that bit 47 of the product is clear in some pairs and set in others. A randomised back-to-back stream with gaps in the valid strobe then checks the three-cycle alignment against a model computed in the bench. A reset pulse with operands in flight confirms that those operands are dropped.

// File: rtl/fp32_mul_pipe.sv
module fp32_mul_pipe #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [EW+FW:0]        op_a,
  input  logic [EW+FW:0]        op_b,
  output logic                  res_valid,
  output logic [EW+FW:0]        res,
  output logic [2*(FW+1)-1:0]   sig_prod,
  output logic                  ovf,
  output logic                  udf
);
  localparam int MW   = FW + 1;
  localparam int PW   = 2 * MW;
  localparam int XW   = EW + 2;
  localparam int EMAX = (1 << EW) - 1;
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EW+FW:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  // stage 1: unpack, classify, add exponents
  wire [EW-1:0] ea = op_a[FW +: EW];
  wire [EW-1:0] eb = op_b[FW +: EW];
  wire za = (ea == '0);
  wire zb = (eb == '0);
  wire ia = (ea == EW'(EMAX)) && (op_a[FW-1:0] == '0);
  wire ib = (eb == EW'(EMAX)) && (op_b[FW-1:0] == '0);
  wire na = (ea == EW'(EMAX)) && (op_a[FW-1:0] != '0);
  wire nb = (eb == EW'(EMAX)) && (op_b[FW-1:0] != '0);

  logic v1, s1, nan1, inf1, zero1;
  logic signed [XW-1:0] e1;
  logic [MW-1:0] ma1, mb1;

  always_ff @(posedge clk) begin
    v1    <= rst ? 1'b0 : op_valid;
    s1    <= op_a[EW+FW] ^ op_b[EW+FW];
    nan1  <= na | nb | (ia & zb) | (ib & za);
    inf1  <= ia | ib;
    zero1 <= za | zb;
    e1    <= $signed({2'b00, ea}) + $signed({2'b00, eb}) - XW'(BIAS);
    ma1   <= {1'b1, op_a[FW-1:0]};
    mb1   <= {1'b1, op_b[FW-1:0]};
  end

  // stage 2: significand product
  logic v2, s2, nan2, inf2, zero2;
  logic signed [XW-1:0] e2;
  logic [PW-1:0] p2;

  always_ff @(posedge clk) begin
    v2    <= rst ? 1'b0 : v1;
    s2    <= s1;
    nan2  <= nan1;
    inf2  <= inf1;
    zero2 <= zero1;
    e2    <= e1;
    p2    <= ma1 * mb1;
  end

  // stage 3: normalise, range check, pack
  wire                  top = p2[PW-1];
  wire [PW-1:0]         pn  = top ? (p2 >> 1) : p2;
  wire signed [XW-1:0]  en  = e2 + XW'(top);
  wire                  big = en > $signed(XW'(EMAX - 1));
  wire                  sml = en < $signed(XW'(1));

  always_ff @(posedge clk) begin
    res_valid <= rst ? 1'b0 : v2;
    ovf       <= 1'b0;
    udf       <= 1'b0;
    sig_prod  <= '0;
    if (nan2)
      res <= QNAN;
    else if (inf2)
      res <= {s2, {EW{1'b1}}, {FW{1'b0}}};
    else if (zero2)
      res <= {s2, {(EW+FW){1'b0}}};
    else if (big) begin
      res <= {s2, {EW{1'b1}}, {FW{1'b0}}};
      ovf <= 1'b1;
    end else if (sml) begin
      res <= {s2, {(EW+FW){1'b0}}};
      udf <= 1'b1;
    end else begin
      res      <= {s2, en[EW-1:0], pn[PW-3 -: FW]};
      sig_prod <= pn;
    end
  end

  AST_LATENCY:   assert property (@(posedge clk) disable iff (rst) res_valid |-> $past(op_valid, 3)); // R2
  AST_RST_CLEAR: assert property (@(posedge clk) $past(rst) |-> !res_valid); // R11
  AST_OVF_INF:   assert property (@(posedge clk) disable iff (rst) ovf |-> (res[EW+FW-1:0] == {{EW{1'b1}}, {FW{1'b0}}})); // R6
  AST_UDF_ZERO:  assert property (@(posedge clk) disable iff (rst) udf |-> (res[EW+FW-1:0] == '0) && !ovf); // R7
  AST_NAN_CODE:  assert property (@(posedge clk) disable iff (rst)
                   (res_valid && res[FW +: EW] == EW'(EMAX) && res[FW-1:0] != '0) |-> (res == QNAN) && !ovf && !udf); // R9
  AST_PROD_NORM: assert property (@(posedge clk) disable iff (rst)
                   (res_valid && sig_prod != '0) |-> (sig_prod[PW-1:PW-2] == 2'b01) && (res[FW-1:0] == sig_prod[PW-3 -: FW])); // R5
endmodule

// File: tb/fp32_mul_pipe_tb.sv
module fp32_mul_pipe_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic res_valid, ovf, udf;
  logic [31:0] res;
  logic [47:0] sig_prod;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp32_mul_pipe u_dut (.clk(clk), .rst(rst), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
                       .res_valid(res_valid), .res(res), .sig_prod(sig_prod), .ovf(ovf), .udf(udf));

  function automatic logic [81:0] model(input logic [31:0] a, input logic [31:0] b);
    logic s, za, zb, ia, ib, na, nb;
    logic [47:0] p;
    int e;
    s  = a[31] ^ b[31];
    za = a[30:23] == 0;           zb = b[30:23] == 0;
    ia = a[30:23] == 255 && a[22:0] == 0;  ib = b[30:23] == 255 && b[22:0] == 0;
    na = a[30:23] == 255 && a[22:0] != 0;  nb = b[30:23] == 255 && b[22:0] != 0;
    if (na || nb || (ia && zb) || (ib && za)) return {32'h7FC00000, 48'd0, 2'b00};
    if (ia || ib) return {s, 31'h7F800000, 48'd0, 2'b00};
    if (za || zb) return {s, 31'd0, 48'd0, 2'b00};
    p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
    e = int'(a[30:23]) + int'(b[30:23]) - 127;
    if (p[47]) begin p = p >> 1; e = e + 1; end
    if (e > 254) return {s, 31'h7F800000, 48'd0, 2'b10};
    if (e < 1)   return {s, 31'd0, 48'd0, 2'b01};
    return {s, 8'(e), p[45:23], p, 2'b00};
  endfunction

  task automatic check(input string req, input logic [81:0] exp_v);
    checks++;
    if (!res_valid || {res, sig_prod, ovf, udf} !== exp_v) begin
      fails++;
      $display("FAIL %s: got v=%b res=%h prod=%h ovf=%b udf=%b, expected v=1 res=%h prod=%h ovf=%b udf=%b",
               req, res_valid, res, sig_prod, ovf, udf, exp_v[81:50], exp_v[49:2], exp_v[1], exp_v[0]);
    end
  endtask

  task automatic one(input string req, input logic [31:0] a, input logic [31:0] b, input logic [81:0] exp_v);
    op_a = a; op_b = b; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(req, exp_v);
    @(negedge clk);
  endtask

  task automatic t_reset;
    checks++;
    if (res_valid !== 1'b0) begin fails++; $display("FAIL R11: res_valid=%b expected 0 after reset", res_valid); end
  endtask

  task automatic t_basic;
    one("R4 1.5*2", 32'h3FC00000, 32'h40000000, {32'h40400000, 48'h600000000000, 2'b00});
    one("R1 1*1", 32'h3F800000, 32'h3F800000, {32'h3F800000, 48'h400000000000, 2'b00});
    one("R5 1.5*1.5 normalise", 32'h3FC00000, 32'h3FC00000, {32'h40100000, 48'h480000000000, 2'b00});
    one("R4 pi*e truncation", 32'h40490FDB, 32'h402DF854, model(32'h40490FDB, 32'h402DF854));
  endtask

  task automatic t_sign;
    one("R3 neg*pos", 32'hBFC00000, 32'h40000000, {32'hC0400000, 48'h600000000000, 2'b00});
    one("R3 neg*neg", 32'hBFC00000, 32'hC0000000, {32'h40400000, 48'h600000000000, 2'b00});
    one("R3 neg zero", 32'h80000000, 32'h3F800000, {32'h80000000, 48'd0, 2'b00});
  endtask

  task automatic t_range;
    one("R6 edge 254 ok", 32'h7F000000, 32'h3F800000, {32'h7F000000, 48'h400000000000, 2'b00});
    one("R6 overflow", 32'h7F000000, 32'h7F000000, {32'h7F800000, 48'd0, 2'b10});
    one("R6 ovf by normalise", 32'h7F400000, 32'h3FC00000, {32'h7F800000, 48'd0, 2'b10});
    one("R6 R3 neg overflow", 32'hFF000000, 32'h7F000000, {32'hFF800000, 48'd0, 2'b10});
    one("R7 edge 1 ok", 32'h00800000, 32'h3F800000, {32'h00800000, 48'h400000000000, 2'b00});
    one("R7 underflow", 32'h00800000, 32'h3F000000, {32'h00000000, 48'd0, 2'b01});
    one("R7 rescued by normalise", 32'h00C00000, 32'h3F400000, {32'h00900000, 48'h480000000000, 2'b00});
    one("R7 R3 neg underflow", 32'h80800000, 32'h00800000, {32'h80000000, 48'd0, 2'b01});
  endtask

  task automatic t_special;
    one("R8 denormal flushed", 32'h00000001, 32'h3F800000, {32'h00000000, 48'd0, 2'b00});
    one("R8 denormal*huge", 32'h007FFFFF, 32'hFF000000, {32'h80000000, 48'd0, 2'b00});
    one("R9 inf*zero", 32'h7F800000, 32'h00000000, {32'h7FC00000, 48'd0, 2'b00});
    one("R9 nan in", 32'hFFC12345, 32'h3F800000, {32'h7FC00000, 48'd0, 2'b00});
    one("R9 denormal*inf", 32'h00000005, 32'hFF800000, {32'h7FC00000, 48'd0, 2'b00});
    one("R10 inf*neg", 32'h7F800000, 32'hC0000000, {32'hFF800000, 48'd0, 2'b00});
    one("R10 inf*inf", 32'hFF800000, 32'hFF800000, {32'h7F800000, 48'd0, 2'b00});
  endtask

  task automatic t_stream;
    logic [31:0] qa [0:39];
    logic [31:0] qb [0:39];
    logic        qv [0:39];
    for (int i = 0; i < 40; i++) begin
      qa[i] = $urandom; qb[i] = $urandom;
      if (i % 3 == 0) begin qa[i][30:29] = 2'b01; qb[i][30:29] = 2'b10; end
      qv[i] = (i % 5) != 4;
    end
    for (int j = 0; j < 43; j++) begin
      if (j >= 3) begin
        if (qv[j-3]) check("R2 stream", model(qa[j-3], qb[j-3]));
        else begin
          checks++;
          if (res_valid !== 1'b0) begin fails++; $display("FAIL R2: gap res_valid=%b expected 0", res_valid); end
        end
      end
      op_valid = (j < 40) ? qv[j] : 1'b0;
      if (j < 40) begin op_a = qa[j]; op_b = qb[j]; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset_flight;
    op_a = 32'h3F800000; op_b = 32'h3F800000; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (res_valid !== 1'b0) begin fails++; $display("FAIL R11: in-flight res_valid=%b expected 0", res_valid); end
      @(negedge clk);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_sign();
    t_range();
    t_special();
    t_stream();
    t_reset_flight();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule